// File: doc/BRIEF.md
# Nibble-Opcode Accumulator Processor

This block is a small single-cycle processor for 8-bit data. Each instruction is one byte. The upper nibble holds the operation code and the lower nibble holds the operand. Program and data share one 256-byte memory. Arithmetic, logic, compare and memory-read results all land in a single 8-bit accumulator. Four 8-bit general registers supply the operands, and the accumulator writes into them.

Immediate constants are built one nibble at a time. One instruction clears the accumulator and loads the low nibble. A second instruction replaces only the high nibble. Control flow is a two-state machine:

- **RUN**: the state after reset. Each clock executes the byte the program counter points at. The transition RUN→RUN covers every instruction except halt. In that transition the counter steps by one, or it takes the branch target.
- **STOPPED**: entered by the transition RUN→STOPPED, taken when the halt opcode executes. The transition STOPPED→STOPPED holds all state frozen. Only reset leads back to RUN.

A preload port writes memory bytes directly, so a program can be placed in memory while reset is held.

Top module: `cpu8_core`

## Requirements
- R1: Synchronous reset sets the program counter to 0, clears the accumulator and all four registers, and clears the halted flag. Memory contents are kept.
- R2: An instruction byte carries the opcode in bits [7:4]. The first register code is in bits [3:2] and the second in bits [1:0], with the codes 00, 01, 10 and 11 naming registers A, B, C and D.
- R3: Opcode 1110 sets the accumulator to {0000, operand[3:0]}. Opcode 1111 replaces accumulator bits [7:4] with operand[3:0] and keeps bits [3:0].
- R4: Opcode 0001 copies the accumulator into the register selected by bits [3:2]. Bits [1:0] have no effect.
- R5: Opcode 0101 gives first+second and opcode 0110 gives first−second, both modulo 256, written to the accumulator.
- R6: Opcode 0100 gives the bitwise AND and opcode 0111 the bitwise OR of the two registers. Opcode 1000 gives the bitwise inverse of the first register. Each result goes to the accumulator.
- R7: Opcodes 1001, 1010 and 1011 write 1 to the accumulator when the first register is equal to, less than or greater than the second register (unsigned), and write 0 otherwise.
- R8: Opcode 0010 loads the accumulator with the memory byte addressed by the first register. Opcode 0011 writes the accumulator to that byte.
- R9: Opcode 1100 jumps to the address held in the first register when accumulator bit 0 is 1. Opcode 1101 makes the same jump when that bit is 0. Otherwise execution falls through to the next byte.
- R10: Execution starts at address 0. Each non-branching instruction advances the program counter by one, and the counter wraps from 255 to 0.
- R11: Opcode 0000 sets the halted flag and leaves the program counter on the halt byte. While halted, the program counter, the accumulator and the halted flag do not change.
- R12: The program E6 F3 10 E3 F0 14 51 00 ends halted with accumulator 0x39 and program counter 7.
- R13: A byte written through the preload port at a clock edge is the value later fetched or read from that address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pre_we | input | 1 | Preload write enable |
| pre_addr | input | 8 | Preload byte address |
| pre_data | input | 8 | Preload byte value |
| acc_o | output | 8 | Accumulator contents |
| halted_o | output | 1 | High in the STOPPED state |
| pc_o | output | 8 | Program counter |

## Verification
The bench uses the default build: 8-bit words, a 256-byte memory and four registers. With these sizes, every register code and the wrap of the program counter from 255 to 0 can be reached by a short program. The ALU operations are swept over 256 operand pairs spaced across the byte range, including equal and adjacent values. Every expected result is computed arithmetically. Directed programs cover the branch decisions, the memory round trip, the ignored copy field and the reference program.

// File: rtl/cpu8_pkg.sv
package cpu8_pkg;
    localparam int WORD_W = 8;
    localparam int NIB_W  = WORD_W / 2;
    localparam int SEL_W  = NIB_W / 2;
    localparam int NREG   = 1 << SEL_W;

    typedef enum logic [NIB_W-1:0] {
        OP_HALT  = 4'h0,
        OP_COPY  = 4'h1,
        OP_LOAD  = 4'h2,
        OP_STOR  = 4'h3,
        OP_AND   = 4'h4,
        OP_ADD   = 4'h5,
        OP_SUB   = 4'h6,
        OP_OR    = 4'h7,
        OP_NOT   = 4'h8,
        OP_EQ    = 4'h9,
        OP_LT    = 4'hA,
        OP_GT    = 4'hB,
        OP_JSET  = 4'hC,
        OP_JCLR  = 4'hD,
        OP_SETLO = 4'hE,
        OP_SETHI = 4'hF
    } opcode_e;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_STOP = 1'b1
    } state_e;
endpackage

// File: rtl/cpu8_mem.sv
module cpu8_mem #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] iaddr,
    output logic [DW-1:0] idata,
    input  logic [AW-1:0] daddr,
    output logic [DW-1:0] ddata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign idata = cells[iaddr];
    assign ddata = cells[daddr];
endmodule

// File: rtl/cpu8_regfile.sv
module cpu8_regfile #(
    parameter int W    = 8,
    parameter int NREG = 4,
    localparam int SW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [SW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [SW-1:0] sel_a,
    input  logic [SW-1:0] sel_b,
    output logic [W-1:0]  val_a,
    output logic [W-1:0]  val_b
);
    logic [W-1:0] bank [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                bank[g] <= '0;
            end else if (we && waddr == SW'(g)) begin
                bank[g] <= wdata;
            end
        end
    end

    assign val_a = bank[sel_a];
    assign val_b = bank[sel_b];
endmodule

// File: rtl/cpu8_alu.sv
module cpu8_alu
    import cpu8_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  opcode_e          opc,
    input  logic [NIB_W-1:0] imm,
    input  logic [W-1:0]     acc,
    input  logic [W-1:0]     ra,
    input  logic [W-1:0]     rb,
    input  logic [W-1:0]     mdata,
    output logic [W-1:0]     res
);
    always_comb begin
        unique case (opc)
            OP_LOAD:  res = mdata;
            OP_AND:   res = ra & rb;
            OP_ADD:   res = ra + rb;
            OP_SUB:   res = ra - rb;
            OP_OR:    res = ra | rb;
            OP_NOT:   res = ~ra;
            OP_EQ:    res = W'(ra == rb);
            OP_LT:    res = W'(ra < rb);
            OP_GT:    res = W'(ra > rb);
            OP_SETLO: res = W'(imm);
            OP_SETHI: res = {imm, acc[NIB_W-1:0]};
            default:  res = acc;
        endcase
    end
endmodule

// File: rtl/cpu8_ctrl.sv
module cpu8_ctrl
    import cpu8_pkg::*;
#(
    parameter int AW = WORD_W
) (
    input  logic          clk,
    input  logic          rst,
    input  opcode_e       opc,
    input  logic [AW-1:0] jump_addr,
    input  logic          acc_bit0,
    output logic [AW-1:0] pc,
    output logic          halted,
    output logic          reg_we,
    output logic          mem_we,
    output logic          acc_we
);
    state_e        state, state_nx;
    logic [AW-1:0] pc_nx;
    logic          take;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_RUN;
            pc    <= '0;
        end else begin
            state <= state_nx;
            pc    <= pc_nx;
        end
    end

    // next state and next program counter
    always_comb begin
        take     = (opc == OP_JSET && acc_bit0) || (opc == OP_JCLR && !acc_bit0);
        state_nx = state;
        pc_nx    = pc;
        unique case (state)
            ST_RUN: begin
                if (opc == OP_HALT) begin
                    state_nx = ST_STOP;
                end else if (take) begin
                    pc_nx = jump_addr;
                end else begin
                    pc_nx = pc + AW'(1);
                end
            end
            ST_STOP: begin
                state_nx = ST_STOP;
            end
        endcase
    end

    // outputs
    always_comb begin
        halted = (state == ST_STOP);
        reg_we = (state == ST_RUN) && (opc == OP_COPY);
        mem_we = (state == ST_RUN) && (opc == OP_STOR);
        acc_we = (state == ST_RUN) &&
                 !(opc inside {OP_HALT, OP_COPY, OP_STOR, OP_JSET, OP_JCLR});
    end

    // R10
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && !(opc inside {OP_HALT, OP_JSET, OP_JCLR}))
        |=> pc == $past(pc) + AW'(1));

    // R11
    pc_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STOP) |=> ($stable(pc) && state == ST_STOP));
endmodule

// File: rtl/cpu8_core.sv
module cpu8_core
    import cpu8_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pre_we,
    input  logic [WORD_W-1:0] pre_addr,
    input  logic [WORD_W-1:0] pre_data,
    output logic [WORD_W-1:0] acc_o,
    output logic              halted_o,
    output logic [WORD_W-1:0] pc_o
);
    logic [WORD_W-1:0] instr, mdata, ra, rb, res, acc_q, pc;
    logic [WORD_W-1:0] mw_addr, mw_data;
    logic              reg_we, mem_we, acc_we, halted;
    opcode_e           opc;
    logic [NIB_W-1:0]  imm;
    logic [SEL_W-1:0]  sel_a, sel_b;

    assign opc   = opcode_e'(instr[WORD_W-1:NIB_W]);
    assign imm   = instr[NIB_W-1:0];
    assign sel_a = instr[NIB_W-1:SEL_W];
    assign sel_b = instr[SEL_W-1:0];

    // preload port wins over a store
    assign mw_addr = pre_we ? pre_addr : ra;
    assign mw_data = pre_we ? pre_data : acc_q;

    cpu8_mem #(.AW(WORD_W), .DW(WORD_W)) u_mem (
        .clk   (clk),
        .we    (pre_we | mem_we),
        .waddr (mw_addr),
        .wdata (mw_data),
        .iaddr (pc),
        .idata (instr),
        .daddr (ra),
        .ddata (mdata)
    );

    cpu8_regfile #(.W(WORD_W), .NREG(NREG)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we),
        .waddr (sel_a),
        .wdata (acc_q),
        .sel_a (sel_a),
        .sel_b (sel_b),
        .val_a (ra),
        .val_b (rb)
    );

    cpu8_alu #(.W(WORD_W)) u_alu (
        .opc   (opc),
        .imm   (imm),
        .acc   (acc_q),
        .ra    (ra),
        .rb    (rb),
        .mdata (mdata),
        .res   (res)
    );

    cpu8_ctrl #(.AW(WORD_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .opc       (opc),
        .jump_addr (ra),
        .acc_bit0  (acc_q[0]),
        .pc        (pc),
        .halted    (halted),
        .reg_we    (reg_we),
        .mem_we    (mem_we),
        .acc_we    (acc_we)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (acc_we) begin
            acc_q <= res;
        end
    end

    assign acc_o    = acc_q;
    assign halted_o = halted;
    assign pc_o     = pc;

    // R3
    setlo_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (!halted && opc == OP_SETLO)
        |=> acc_q == {{NIB_W{1'b0}}, $past(instr[NIB_W-1:0])});

    // R3
    sethi_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (!halted && opc == OP_SETHI)
        |=> acc_q[NIB_W-1:0] == $past(acc_q[NIB_W-1:0]));

    // R7
    cmp_bool_chk: assert property (@(posedge clk) disable iff (rst)
        (!halted && opc inside {OP_EQ, OP_LT, OP_GT})
        |=> acc_q[WORD_W-1:1] == '0);

    // R11
    acc_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        halted |=> ($stable(acc_q) && halted));
endmodule

// File: tb/tb_cpu8_core.sv
module tb_cpu8_core;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pre_we = 1'b0;
    logic [7:0] pre_addr = '0;
    logic [7:0] pre_data = '0;
    logic [7:0] acc_o, pc_o;
    logic       halted_o;

    int vectors = 0;
    int fails   = 0;
    int cyc     = 0;

    cpu8_core dut (
        .clk(clk), .rst(rst), .pre_we(pre_we), .pre_addr(pre_addr),
        .pre_data(pre_data), .acc_o(acc_o), .halted_o(halted_o), .pc_o(pc_o)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            fails++;
            $display("FAIL watchdog R10: actual=%0d cycles expected=<190000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, got, exp);
        end
    endtask

    // called at a falling edge, returns at the next falling edge
    task automatic poke(input logic [7:0] a, input logic [7:0] d);
        pre_we = 1'b1; pre_addr = a; pre_data = d;
        @(negedge clk);
        pre_we = 1'b0;
    endtask

    task automatic hold_reset();
        rst = 1'b1;
        @(negedge clk);
    endtask

    task automatic set_reg(inout int a, input logic [1:0] r, input logic [7:0] v);
        poke(8'(a),     {4'hE, v[3:0]});
        poke(8'(a + 1), {4'hF, v[7:4]});
        poke(8'(a + 2), {4'h1, r, 2'b00});
        a += 3;
    endtask

    task automatic run_to_halt(input string tag);
        bit done = 0;
        rst = 1'b0;
        for (int i = 0; i < 700; i++) begin
            @(negedge clk);
            if (halted_o) begin done = 1; break; end
        end
        if (!done) begin
            vectors++; fails++;
            $display("FAIL %s: actual=running expected=halted", tag);
        end
    endtask

    initial begin
        logic [7:0] ops [8];
        logic [7:0] a, b, e;
        int p;
        ops = '{8'h51, 8'h61, 8'h41, 8'h71, 8'h81, 8'h91, 8'hA1, 8'hB1};

        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 pc", pc_o, 8'h00);
        chk("R1 acc", acc_o, 8'h00);
        chk("R1 halted", {7'b0, halted_o}, 8'h00);

        // R12 reference program, R3 nibble build, R10 stepping, R13 preload
        poke(0, 8'hE6); poke(1, 8'hF3); poke(2, 8'h10); poke(3, 8'hE3);
        poke(4, 8'hF0); poke(5, 8'h14); poke(6, 8'h51); poke(7, 8'h00);
        rst = 1'b0;
        @(negedge clk);
        chk("R3 low nibble set", acc_o, 8'h06);
        chk("R10 pc step", pc_o, 8'h01);
        @(negedge clk);
        chk("R3 high nibble set", acc_o, 8'h36);
        chk("R10 pc step", pc_o, 8'h02);
        run_to_halt("R12");
        chk("R12 acc", acc_o, 8'h39);
        chk("R12 pc", pc_o, 8'h07);
        chk("R12 halted", {7'b0, halted_o}, 8'h01);
        repeat (5) @(negedge clk);
        chk("R11 acc frozen", acc_o, 8'h39);
        chk("R11 pc frozen", pc_o, 8'h07);
        chk("R11 still halted", {7'b0, halted_o}, 8'h01);

        // R1 registers cleared: A held 0x36 before this reset
        hold_reset();
        poke(0, 8'h51); poke(1, 8'h00);
        run_to_halt("R1");
        chk("R1 registers cleared", acc_o, 8'h00);

        // R11 halt as first instruction
        hold_reset();
        poke(0, 8'h00);
        run_to_halt("R11");
        chk("R11 halt at 0 pc", pc_o, 8'h00);
        chk("R11 halt at 0 acc", acc_o, 8'h00);

        // R5 R6 R7 sweep over operand pairs in registers A and B
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                a = 8'(i * 17);
                b = 8'(j * 17 + (i % 3) - 1);
                hold_reset();
                p = 0;
                set_reg(p, 2'b00, a);
                set_reg(p, 2'b01, b);
                poke(7, 8'h00);
                for (int k = 0; k < 8; k++) begin
                    hold_reset();
                    poke(6, ops[k]);
                    run_to_halt("R5 sweep");
                    case (k)
                        0: e = 8'(a + b);
                        1: e = 8'(a - b);
                        2: e = a & b;
                        3: e = a | b;
                        4: e = ~a;
                        5: e = {7'b0, a == b};
                        6: e = {7'b0, a < b};
                        default: e = {7'b0, a > b};
                    endcase
                    if (k < 2)      chk("R5 add/sub", acc_o, e);
                    else if (k < 5) chk("R6 logic", acc_o, e);
                    else            chk("R7 compare", acc_o, e);
                end
            end
        end

        // R2 register fields: C and D
        for (int t = 0; t < 4; t++) begin
            a = 8'(t * 61 + 3);
            b = 8'(t * 29 + 200);
            hold_reset();
            p = 0;
            set_reg(p, 2'b10, a);
            set_reg(p, 2'b11, b);
            poke(6, 8'h6E); poke(7, 8'h00);
            run_to_halt("R2");
            chk("R2 D minus C", acc_o, 8'(b - a));
            hold_reset();
            poke(6, 8'h6B);
            run_to_halt("R2");
            chk("R2 C minus D", acc_o, 8'(a - b));
            hold_reset();
            poke(6, 8'h8E);
            run_to_halt("R2");
            chk("R2 inverse of D", acc_o, ~b);
        end

        // R4 copy ignores bits [1:0]: copy into A with D coded below
        hold_reset();
        poke(0, 8'hE5); poke(1, 8'h13); poke(2, 8'hE1); poke(3, 8'h5C); poke(4, 8'h00);
        run_to_halt("R4");
        chk("R4 copy field ignored", acc_o, 8'h05);

        // R8 store and load, R13 preloaded data byte
        hold_reset();
        poke(8'hC0, 8'hA7);
        p = 0;
        set_reg(p, 2'b00, 8'h80);
        set_reg(p, 2'b01, 8'hC0);
        poke(6, 8'hEA); poke(7, 8'hF5); poke(8, 8'h30); poke(9, 8'h24); poke(10, 8'h00);
        run_to_halt("R8");
        chk("R13 preloaded byte read", acc_o, 8'hA7);
        hold_reset();
        poke(8'h80, 8'h00);
        poke(10, 8'h20); poke(11, 8'h00);
        run_to_halt("R8");
        chk("R8 store then load", acc_o, 8'h5A);

        // R9 conditional jumps on accumulator bit 0
        for (int t = 0; t < 4; t++) begin
            logic taken;
            hold_reset();
            p = 0;
            set_reg(p, 2'b00, 8'h30);
            poke(3, (t % 2 == 1) ? 8'hE3 : 8'hE2);
            poke(4, (t < 2) ? 8'hC0 : 8'hD0);
            poke(5, 8'hE9); poke(6, 8'h00);
            poke(8'h30, 8'hE7); poke(8'h31, 8'h00);
            run_to_halt("R9");
            taken = (t < 2) ? (t % 2 == 1) : (t % 2 == 0);
            chk("R9 branch acc", acc_o, taken ? 8'h07 : 8'h09);
            chk("R9 branch pc", pc_o, taken ? 8'h31 : 8'h06);
        end

        // R10 wrap from 255 to 0
        hold_reset();
        poke(0, 8'hC4); poke(1, 8'hE0); poke(2, 8'hF4); poke(3, 8'h14);
        poke(4, 8'hEE); poke(5, 8'hFF); poke(6, 8'h18); poke(7, 8'hE0);
        poke(8, 8'hD8); poke(8'hFE, 8'hE1); poke(8'hFF, 8'hF6); poke(8'h40, 8'h00);
        run_to_halt("R10");
        chk("R10 wrap acc", acc_o, 8'h61);
        chk("R10 wrap pc", pc_o, 8'h40);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule